// File: doc/BRIEF.md
# External Interrupt Request Controller

This block serves one active-low external interrupt pin of a small microcontroller. The pin is brought into the clock domain through a chain of synchronising flops. A high-to-low transition of the synchronised level sets a pending latch. In one trigger mode, a low level held on the pin also keeps setting the latch. The latch drives an interrupt request towards the CPU, and a mask bit can block that request. Masked events still set the latch.

Software reaches the block through one byte-wide control/status register on a simple bus (address, write strobe, write data, read strobe, registered read data). Writing a 1 to the acknowledge bit clears the latch. While a debug halt is in progress, that acknowledge only works when a separate clear-enable input permits it. The halt logic, vectoring and arbitration between sources lie outside the block and arrive only as input signals.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the pending latch, mask, trigger mode, `cpu_irq` and `bus_rdata` are all 0.
- R2: The register reads as {4'b0000, pending, 1'b0, mask, mode}: pending is bit 3, the acknowledge position (bit 2) always reads 0, mask is bit 1, mode is bit 0, and bits 7..4 read 0.
- R3: A falling edge of the synchronised pin sets the latch in either mode. A rising edge, or a pin that stays high, never sets it.
- R4: In mode 0 (edge only), an acknowledge (write with bit 2 = 1) clears the latch even while the pin is still held low. The latch stays clear until the next falling edge.
- R5: In mode 1 (edge and low level), a synchronised low level sets the latch on every clock, so an acknowledge does not leave it cleared while the pin stays low.
- R6: With the halt input low, writing 1 to bit 2 clears the latch when no set event occurs in that cycle.
- R7: With the halt input high and the clear-enable input low, an acknowledge write leaves the latch unchanged.
- R8: With the halt input high and the clear-enable input high, an acknowledge write clears the latch, and the latch stays clear after the halt ends.
- R9: When a set event and an acknowledge write fall in the same cycle, the latch ends up set.
- R10: `cpu_irq` equals pending AND NOT mask at every cycle. A masked event still sets the pending bit, and clearing the mask later raises `cpu_irq`.
- R11: Writes to any address other than `REG_ADDR` change nothing, and reads of any other address return 0.
- R12: Read data appears on `bus_rdata` in the cycle after the read strobe and is 0 in any cycle not following a read strobe to `REG_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| dbg_halt | input | 1 | Debug halt state is active |
| dbg_clr_en | input | 1 | Allows the acknowledge to clear the latch during a halt |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench builds the block with `SYNC_STAGES = 3`, `ADDR_W = 6` and `REG_ADDR = 6'h2A`, so none of the values are defaults. The deeper synchroniser shows that the same-cycle race between a new edge and an acknowledge is timed from the parameter, not from a fixed two-flop delay. The narrow, non-zero address lets the bench probe a neighbouring address and confirm that the register decodes only its own location.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CSR_W    = 8;
  localparam int BIT_PEND = 3;
  localparam int BIT_ACK  = 2;
  localparam int BIT_MASK = 1;
  localparam int BIT_MODE = 0;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_e;

  typedef struct packed {
    logic  mask;
    trig_e mode;
  } ctrl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic lvl_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("ext_irq_sync needs at least two stages");
    end
  endgenerate

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[LAST];
  end

  assign lvl_o  = chain_q[LAST];
  assign fall_o = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/ext_irq_csr.sv
module ext_irq_csr
  import ext_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [CSR_W-1:0]  wdata,
  input  logic              rd,
  input  logic              pend_i,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_d,
  output logic              ack_o,
  output logic [CSR_W-1:0]  rdata_o
);
  logic hit;
  logic unused_wbits;

  assign hit          = (addr == REG_ADDR);
  assign unused_wbits = ^wdata[CSR_W-1:BIT_PEND];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && hit) begin
      ctrl_d.mask = wdata[BIT_MASK];
      ctrl_d.mode = trig_e'(wdata[BIT_MODE]);
    end
  end

  assign ack_o = wr & hit & wdata[BIT_ACK];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '{mask: 1'b0, mode: TRIG_EDGE};
    else     ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd && hit) begin
      rdata_o           <= '0;
      rdata_o[BIT_PEND] <= pend_i;
      rdata_o[BIT_MASK] <= ctrl_q.mask;
      rdata_o[BIT_MODE] <= ctrl_q.mode;
    end else begin
      rdata_o <= '0;
    end
  end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fall_i,
  input  logic  lvl_i,
  input  trig_e mode_i,
  input  logic  mask_d_i,
  input  logic  ack_i,
  input  logic  halt_i,
  input  logic  clr_en_i,
  output logic  pend_o,
  output logic  irq_o
);
  logic set_evt;
  logic clr_ok;
  logic pend_d;

  assign set_evt = fall_i | ((mode_i == TRIG_EDGE_LEVEL) & ~lvl_i);
  assign clr_ok  = ack_i & (~halt_i | clr_en_i);
  // a new event outranks a clear in the same cycle
  assign pend_d  = set_evt | (pend_o & ~clr_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      irq_o  <= pend_d & ~mask_d_i;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h40,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              dbg_halt,
  input  logic              dbg_clr_en,
  output logic              cpu_irq
);
  logic  sync_lvl;
  logic  sync_fall;
  logic  pend_q;
  logic  ack_w;
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_n  (irq_pin_n),
    .lvl_o  (sync_lvl),
    .fall_o (sync_fall)
  );

  ext_irq_csr #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_csr (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .wdata   (bus_wdata),
    .rd      (bus_rd),
    .pend_i  (pend_q),
    .ctrl_q  (ctrl_q),
    .ctrl_d  (ctrl_d),
    .ack_o   (ack_w),
    .rdata_o (bus_rdata)
  );

  ext_irq_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .fall_i   (sync_fall),
    .lvl_i    (sync_lvl),
    .mode_i   (ctrl_q.mode),
    .mask_d_i (ctrl_d.mask),
    .ack_i    (ack_w),
    .halt_i   (dbg_halt),
    .clr_en_i (dbg_clr_en),
    .pend_o   (pend_q),
    .irq_o    (cpu_irq)
  );
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              ack_bit,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              dbg_halt,
  input logic              dbg_clr_en,
  input logic              cpu_irq,
  input logic              pend,
  input logic              mask,
  input logic              mode,
  input logic              sync_lvl
);
  logic ack_wr;
  assign ack_wr = bus_wr && (bus_addr == REG_ADDR) && ack_bit;

  p_rd_layout_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[7:4] == 4'b0 && bus_rdata[2] == 1'b0);

  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
    (!pend && sync_lvl) |=> !pend);

  p_level_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (mode && !sync_lvl) |=> pend);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && (!dbg_halt || dbg_clr_en) && sync_lvl) |=> !pend);

  p_halt_protects_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && dbg_halt && !dbg_clr_en && pend) |=> pend);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (pend && !mask));

  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 8'h00);
endmodule

bind ext_irq_ctrl ext_irq_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .ack_bit    (bus_wdata[2]),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .dbg_halt   (dbg_halt),
  .dbg_clr_en (dbg_clr_en),
  .cpu_irq    (cpu_irq),
  .pend       (pend_q),
  .mask       (ctrl_q.mask),
  .mode       (ctrl_q.mode),
  .sync_lvl   (sync_lvl)
);

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
  localparam int         AW   = 6;
  localparam logic [5:0] RA   = 6'h2A;
  localparam int         SYNC = 3;

  // vector: {mode, mask, pin[1:0], ack, halt, clr_en, exp_pend, exp_irq}
  // pin: 0 idle high, 1 low pulse then high, 2 held low
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_01_000_1_1,  // R3 edge sets
    9'b0_1_01_000_1_0,  // R10 masked still pends
    9'b0_0_01_100_0_0,  // R6 ack clears
    9'b0_0_10_100_0_0,  // R4 edge mode, held low, ack stays clear
    9'b1_0_10_100_1_1,  // R5 level mode re-asserts
    9'b1_0_01_100_0_0,  // R6 level mode after release clears
    9'b0_0_01_110_1_1,  // R7 halt protects latch
    9'b0_0_01_111_0_0,  // R8 halt with clear-enable clears
    9'b1_0_00_000_0_0,  // R3 no pin activity
    9'b1_1_10_000_1_0   // R10 level held, masked
  };

  logic          clk = 0, rst = 1, pin_n = 1;
  logic [AW-1:0] addr = '0;
  logic          wr = 0, rd = 0, halt = 0, clr_en = 0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  ext_irq_ctrl #(.ADDR_W(AW), .REG_ADDR(RA), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .irq_pin_n(pin_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .dbg_halt(halt),
    .dbg_clr_en(clr_en), .cpu_irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    logic [8:0] v;
    idle(3); rst = 0; idle(1);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    chk("R12 rdata idle", rdata, 8'h00);
    bus_read(RA, r);
    chk("R1 register after reset", r, 8'h00);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      pin_n = 1; halt = 0; clr_en = 0; idle(SYNC + 3);
      bus_write(RA, 8'h04);
      bus_write(RA, {6'b0, v[7], v[8]});
      if (v[6:5] == 2'd1) begin pin_n = 0; idle(SYNC + 2); pin_n = 1; idle(SYNC + 2); end
      else if (v[6:5] == 2'd2) begin pin_n = 0; idle(SYNC + 3); end
      else idle(SYNC + 3);
      if (v[4]) begin
        halt = v[3]; clr_en = v[2];
        bus_write(RA, {5'b0, 1'b1, v[7], v[8]});
        halt = 0; clr_en = 0; idle(2);
      end
      chk($sformatf("R3-table irq vec %0d (R4 R5 R6 R7 R8 R10)", k), {7'b0, irq}, {7'b0, v[0]});
      bus_read(RA, r);
      chk($sformatf("R3-table pend vec %0d", k), {7'b0, r[3]}, {7'b0, v[1]});
      pin_n = 1;
    end

    // R2 layout: write all ones, ack bit reads 0, upper bits 0
    idle(SYNC + 3);
    bus_write(RA, 8'hFF);
    bus_read(RA, r);
    chk("R2 layout after 0xFF", r, 8'h03);
    // R10 masked event latches, unmask raises irq
    bus_write(RA, 8'h02);
    pin_n = 0; idle(SYNC + 2); pin_n = 1; idle(SYNC + 2);
    bus_read(RA, r);
    chk("R10 masked pend", r, 8'h0A);
    chk("R10 masked irq", {7'b0, irq}, 8'h00);
    bus_write(RA, 8'h00);
    chk("R10 unmask irq", {7'b0, irq}, 8'h01);
    // R11 other address ignored
    bus_write(RA + 1, 8'h07);
    bus_read(RA, r);
    chk("R11 foreign write ignored", r, 8'h08);
    bus_read(RA + 1, r);
    chk("R11 foreign read zero", r, 8'h00);
    // R12 read data valid one cycle after strobe, then zero
    @(negedge clk); addr = RA; rd = 1;
    @(negedge clk); rd = 0;
    chk("R12 rdata after strobe", rdata, 8'h08);
    @(negedge clk);
    chk("R12 rdata returns to zero", rdata, 8'h00);

    // R9 race: ack in the cycle the new edge sets the latch
    bus_write(RA, 8'h04);
    bus_read(RA, r);
    chk("R9 precondition clear", r, 8'h00);
    @(negedge clk); pin_n = 0;
    idle(SYNC);
    addr = RA; wdata = 8'h04; wr = 1;
    @(negedge clk); wr = 0;
    bus_read(RA, r);
    chk("R9 set wins over ack", r, 8'h08);
    pin_n = 1;

    // R1 reset in the middle of activity
    bus_write(RA, 8'h03);
    @(negedge clk); rst = 1; idle(2); rst = 0; idle(1);
    chk("R1 irq after mid reset", {7'b0, irq}, 8'h00);
    bus_read(RA, r);
    chk("R1 register after mid reset", r, 8'h00);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule